// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block schedules instructions onto a small set of multi-cycle functional units that share one register file. It does no arithmetic. It keeps one status entry per functional unit and a table that records, for each register, which unit will write it next. From these it decides three things: whether a decoded instruction may be accepted, when each unit may read its operands, and which finished unit may write its result back.

An instruction enters through a valid/ready issue port. It names a target unit by index, a destination register and two source registers. Acceptance is refused when the target unit is occupied or when the destination already has a pending writer. A read-after-write dependency does not block acceptance. Instead, the unit's go pulse is held back until every producer it depends on has written the register file, because results are never forwarded. A unit that has finished raises its request line and holds it. The block answers with a write grant. The grant is withheld while another held instruction still has to read the old value of the same register, and a fixed priority settles ties between requesters.

Back-pressure rules: a transfer happens only in a cycle where iss_valid and iss_ready are both high. iss_ready is a function of the payload and the internal state, never of iss_valid. A sender that sees iss_ready low must hold its payload stable until the transfer happens. The unit-side go, request and grant lines are plain pulses and levels, with no handshake.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset no unit is occupied and no register has a pending writer. iss_ready is high for any payload, and fu_go, fu_wgrant and wb_valid are all zero.
- R2: iss_ready is low while the unit selected by iss_unit holds an instruction. The index on iss_unit runs 0..3, and the internal unit id is the index plus 1, with id 0 meaning "no unit". The same unit can be accepted again in the cycle after its write grant.
- R3: iss_ready is low while iss_dst is the destination of any instruction that has not yet been granted its write.
- R4: A pending producer of a source register does not lower iss_ready. The consumer's fu_go is never asserted before the cycle that follows the producer's write grant, since there is no forwarding.
- R5: fu_go[u] is high for exactly one cycle per accepted instruction. That is the operand-read cycle, and it comes only when neither source has a pending producer.
- R6: The write grant for unit s is withheld while any other occupied unit still has to read the register that s writes (that source is marked ready and has not been read).
- R7: fu_wgrant[u] rises only while fu_done[u] is high, and only after unit u's operand read. The unit must hold fu_done until granted. The grant frees the unit, clears the destination's pending mark if that mark still names u, and marks every source waiting on u as ready.
- R8: At most one grant is given per cycle. Among the eligible requesters the highest index wins: index 3 (divide) beats index 2 (multiply), which beats indices 1 and 0.
- R9: An instruction accepted in the same cycle as the write grant of its source's producer treats that source as ready, so its fu_go may come in the next cycle.
- R10: wb_valid is high exactly in the cycles with a grant, and wb_reg then carries the granted unit's destination register.
- R11: A payload presented with iss_valid low changes no state. The same payload is still acceptable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue payload present |
| iss_ready | output | 1 | Payload can be accepted this cycle |
| iss_unit | input | 2 | Target unit index (0..3) |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| fu_go | output | 4 | Per-unit operand-read pulse |
| fu_done | input | 4 | Per-unit write-back request, held until granted |
| fu_wgrant | output | 4 | Per-unit write grant, one-hot or zero |
| wb_valid | output | 1 | A result is written this cycle |
| wb_reg | output | 3 | Register being written |

## Verification
The bound checker watches the following every cycle:
- the grant vector is one-hot or zero;
- a grant always comes with a request, and only after that unit's go pulse;
- each go pulse lasts a single cycle;
- an accepted unit and an accepted destination are refused again in the very next cycle.

Some behaviour only the bench scenarios can show, because it depends on how several instructions relate to each other. This covers read-after-write ordering with no forwarding, the write-after-read hold against a reader that is still waiting, the same-cycle release of a source, and the priority choice between coinciding requesters. To show these, a reference model replays the status rules on long, hazard-dense instruction streams. Directed sequences add cycle-order checks for the dependent cases.

// File: rtl/sbh_pkg.sv
package sbh_pkg;
  parameter int unsigned FU_COUNT  = 4;
  parameter int unsigned REG_COUNT = 8;

  localparam int unsigned FU_SEL_W = (FU_COUNT > 1) ? $clog2(FU_COUNT) : 1;
  localparam int unsigned FU_ID_W  = $clog2(FU_COUNT + 1);
  localparam int unsigned REG_W    = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  typedef logic [FU_SEL_W-1:0] fu_sel_t;
  typedef logic [FU_ID_W-1:0]  fu_id_t;   // 0 = no unit, else index + 1
  typedef logic [REG_W-1:0]    reg_idx_t;

  localparam fu_id_t NO_FU = '0;

  // One status entry per functional unit. The unit type is fixed by its
  // index, so no operation field is stored.
  typedef struct packed {
    logic     busy;     // holds an instruction
    logic     rd_done;  // operands have been read
    reg_idx_t fi;       // destination
    reg_idx_t fj;       // first source
    reg_idx_t fk;       // second source
    fu_id_t   qj;       // producer of fj, NO_FU when none
    fu_id_t   qk;       // producer of fk, NO_FU when none
    logic     rj;       // fj ready and not yet read
    logic     rk;       // fk ready and not yet read
  } fu_entry_t;

  function automatic fu_id_t sel_to_id(fu_sel_t s);
    return fu_id_t'(s) + fu_id_t'(1);
  endfunction
endpackage

// File: rtl/sbh_result_table.sv
module sbh_result_table
  import sbh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_en,
  input  reg_idx_t set_reg,
  input  fu_id_t   set_id,
  input  logic     clr_en,
  input  reg_idx_t clr_reg,
  input  fu_id_t   clr_id,
  input  reg_idx_t look_a,
  input  reg_idx_t look_b,
  input  reg_idx_t look_c,
  output fu_id_t   prod_a,
  output fu_id_t   prod_b,
  output fu_id_t   prod_c
);
  fu_id_t owner [REG_COUNT];

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        owner[r] <= NO_FU;
      end else if (set_en && set_reg == reg_idx_t'(r)) begin
        owner[r] <= set_id;
      end else if (clr_en && clr_reg == reg_idx_t'(r) && owner[r] == clr_id) begin
        // Only the unit still named as writer may release the mark
        owner[r] <= NO_FU;
      end
    end
  end

  assign prod_a = owner[look_a];
  assign prod_b = owner[look_b];
  assign prod_c = owner[look_c];
endmodule

// File: rtl/sbh_unit_entry.sv
module sbh_unit_entry
  import sbh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      issue_we,
  input  reg_idx_t  iss_dst,
  input  reg_idx_t  iss_src1,
  input  reg_idx_t  iss_src2,
  input  fu_id_t    src1_prod,
  input  fu_id_t    src2_prod,
  input  fu_id_t    wb_id,
  input  logic      wb_self,
  output logic      go,
  output fu_entry_t ent
);
  // Read permission: both sources resolved and not yet consumed
  assign go = ent.busy && !ent.rd_done && ent.rj && ent.rk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent <= '0;
    end else if (wb_self) begin
      ent <= '0;
    end else if (issue_we) begin
      ent.busy    <= 1'b1;
      ent.rd_done <= 1'b0;
      ent.fi      <= iss_dst;
      ent.fj      <= iss_src1;
      ent.fk      <= iss_src2;
      ent.qj      <= src1_prod;
      ent.qk      <= src2_prod;
      ent.rj      <= (src1_prod == NO_FU);
      ent.rk      <= (src2_prod == NO_FU);
    end else if (go) begin
      // Operands consumed: drop ready flags so no stale read hold remains
      ent.rd_done <= 1'b1;
      ent.rj      <= 1'b0;
      ent.rk      <= 1'b0;
    end else begin
      if (wb_id != NO_FU && ent.qj == wb_id) begin
        ent.qj <= NO_FU;
        ent.rj <= 1'b1;
      end
      if (wb_id != NO_FU && ent.qk == wb_id) begin
        ent.qk <= NO_FU;
        ent.rk <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbh_wb_arbiter.sv
module sbh_wb_arbiter
  import sbh_pkg::*;
(
  input  fu_entry_t [FU_COUNT-1:0] ent,
  input  logic      [FU_COUNT-1:0] req,
  output logic      [FU_COUNT-1:0] grant,
  output logic                     wb_valid,
  output fu_id_t                   wb_id,
  output reg_idx_t                 wb_reg
);
  logic [FU_COUNT-1:0] war_hold;
  logic [FU_COUNT-1:0] eligible;

  // A writer is held while another unit still owes a read of its target
  always_comb begin
    war_hold = '0;
    for (int s = 0; s < FU_COUNT; s++) begin
      for (int i = 0; i < FU_COUNT; i++) begin
        if (i != s && ent[i].busy &&
            ((ent[i].fj == ent[s].fi && ent[i].rj) ||
             (ent[i].fk == ent[s].fi && ent[i].rk))) begin
          war_hold[s] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < FU_COUNT; s++) begin
      eligible[s] = req[s] && ent[s].busy && ent[s].rd_done && !war_hold[s];
    end
  end

  // Fixed priority: the highest index wins (later loop iterations override)
  always_comb begin
    grant  = '0;
    wb_id  = NO_FU;
    wb_reg = '0;
    for (int s = 0; s < FU_COUNT; s++) begin
      if (eligible[s]) begin
        grant    = '0;
        grant[s] = 1'b1;
        wb_id    = fu_id_t'(s + 1);
        wb_reg   = ent[s].fi;
      end
    end
  end

  assign wb_valid = |eligible;
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
  import sbh_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  output logic                iss_ready,
  input  logic [FU_SEL_W-1:0] iss_unit,
  input  logic [REG_W-1:0]    iss_dst,
  input  logic [REG_W-1:0]    iss_src1,
  input  logic [REG_W-1:0]    iss_src2,
  output logic [FU_COUNT-1:0] fu_go,
  input  logic [FU_COUNT-1:0] fu_done,
  output logic [FU_COUNT-1:0] fu_wgrant,
  output logic                wb_valid,
  output logic [REG_W-1:0]    wb_reg
);
  fu_entry_t [FU_COUNT-1:0] ent;
  fu_id_t dst_owner, s1_owner, s2_owner;
  fu_id_t s1_prod, s2_prod, wb_id, iss_id;
  logic   unit_ok, issue_fire;

  assign unit_ok    = (32'(iss_unit) < FU_COUNT);
  assign iss_id     = sel_to_id(iss_unit);
  assign iss_ready  = unit_ok && !ent[iss_unit].busy && (dst_owner == NO_FU);
  assign issue_fire = iss_valid && iss_ready;

  // A producer writing back in this very cycle no longer blocks the source
  assign s1_prod = (s1_owner == wb_id) ? NO_FU : s1_owner;
  assign s2_prod = (s2_owner == wb_id) ? NO_FU : s2_owner;

  sbh_result_table u_rtab (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (issue_fire),
    .set_reg (iss_dst),
    .set_id  (iss_id),
    .clr_en  (wb_valid),
    .clr_reg (wb_reg),
    .clr_id  (wb_id),
    .look_a  (iss_dst),
    .look_b  (iss_src1),
    .look_c  (iss_src2),
    .prod_a  (dst_owner),
    .prod_b  (s1_owner),
    .prod_c  (s2_owner)
  );

  for (genvar u = 0; u < FU_COUNT; u++) begin : g_unit
    sbh_unit_entry u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_we  (issue_fire && iss_unit == fu_sel_t'(u)),
      .iss_dst   (iss_dst),
      .iss_src1  (iss_src1),
      .iss_src2  (iss_src2),
      .src1_prod (s1_prod),
      .src2_prod (s2_prod),
      .wb_id     (wb_id),
      .wb_self   (fu_wgrant[u]),
      .go        (fu_go[u]),
      .ent       (ent[u])
    );
  end

  sbh_wb_arbiter u_arb (
    .ent      (ent),
    .req      (fu_done),
    .grant    (fu_wgrant),
    .wb_valid (wb_valid),
    .wb_id    (wb_id),
    .wb_reg   (wb_reg)
  );
endmodule

// File: rtl/sbh_checker.sv
module sbh_checker
  import sbh_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                iss_valid,
  input logic                iss_ready,
  input logic [FU_SEL_W-1:0] iss_unit,
  input logic [REG_W-1:0]    iss_dst,
  input logic [FU_COUNT-1:0] fu_go,
  input logic [FU_COUNT-1:0] fu_done,
  input logic [FU_COUNT-1:0] fu_wgrant
);
  logic [FU_COUNT-1:0] read_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      read_seen <= '0;
    end else begin
      for (int u = 0; u < FU_COUNT; u++) begin
        if (fu_wgrant[u])   read_seen[u] <= 1'b0;
        else if (fu_go[u])  read_seen[u] <= 1'b1;
      end
    end
  end

  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fu_wgrant));

  p_unit_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !(iss_ready && iss_unit == $past(iss_unit)));

  p_dst_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !(iss_ready && iss_dst == $past(iss_dst)));

  for (genvar u = 0; u < FU_COUNT; u++) begin : g_chk
    p_go_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fu_go[u] |=> !fu_go[u]);

    p_grant_has_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fu_wgrant[u] |-> fu_done[u]);

    p_grant_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fu_wgrant[u] |-> read_seen[u]);
  end
endmodule

bind sb_hazard_ctrl sbh_checker i_sbh_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_unit  (iss_unit),
  .iss_dst   (iss_dst),
  .fu_go     (fu_go),
  .fu_done   (fu_done),
  .fu_wgrant (fu_wgrant)
);

// File: tb/test_sb_hazard_ctrl.sv
`timescale 1ns/1ps
module test_sb_hazard_ctrl;
  import sbh_pkg::*;
  localparam int NF = FU_COUNT;
  localparam int NR = REG_COUNT;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                iss_valid = 1'b0;
  logic                iss_ready;
  logic [FU_SEL_W-1:0] iss_unit = '0;
  logic [REG_W-1:0]    iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic [NF-1:0]       fu_go, fu_wgrant;
  logic [NF-1:0]       fu_done = '0;
  logic                wb_valid;
  logic [REG_W-1:0]    wb_reg;

  always #2.5 clk = ~clk;

  sb_hazard_ctrl i_sb_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_unit(iss_unit), .iss_dst(iss_dst), .iss_src1(iss_src1),
    .iss_src2(iss_src2), .fu_go(fu_go), .fu_done(fu_done),
    .fu_wgrant(fu_wgrant), .wb_valid(wb_valid), .wb_reg(wb_reg)
  );

  typedef struct {
    bit          rdy;
    bit [NF-1:0] go;
    bit [NF-1:0] gnt;
    bit          wbv;
    int          wbr;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  int go_at[NF], gnt_at[NF];
  int unsigned seed = 32'h1234_5678;

  // reference model state
  bit m_busy[NF], m_rd[NF], m_rj[NF], m_rk[NF];
  int m_fi[NF], m_fj[NF], m_fk[NF], m_qj[NF], m_qk[NF], cnt[NF];
  int m_rs[NR];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  function automatic int lat_of(int u);
    return (u * u + u) / 2;
  endfunction

  task automatic chk(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // monitor: pops the expected item of this cycle and compares
  always @(negedge clk) begin
    #2;
    for (int u = 0; u < NF; u++) begin
      if (fu_go[u])     go_at[u]  = cyc;
      if (fu_wgrant[u]) gnt_at[u] = cyc;
    end
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R2 R3 R7 R11 iss_ready", int'(iss_ready), int'(e.rdy));
      chk("R4 R5 R9 fu_go", int'(fu_go), int'(e.go));
      chk("R6 R7 R8 fu_wgrant", int'(fu_wgrant), int'(e.gnt));
      chk("R10 wb_valid", int'(wb_valid), int'(e.wbv));
      if (e.wbv) chk("R10 wb_reg", int'(wb_reg), e.wbr);
    end
  end

  // driver: one cycle of stimulus, expected item pushed, model advanced
  task automatic step(input bit v, input int unit, input int dst,
                      input int s1, input int s2, output bit acc);
    exp_t e;
    int gsel, wid, p1, p2;
    bit war, fire;
    @(negedge clk);
    iss_valid = v;
    iss_unit  = FU_SEL_W'(unit);
    iss_dst   = REG_W'(dst);
    iss_src1  = REG_W'(s1);
    iss_src2  = REG_W'(s2);
    for (int u = 0; u < NF; u++)
      fu_done[u] = m_busy[u] && m_rd[u] && cnt[u] == 0;
    #1;
    for (int u = 0; u < NF; u++)
      e.go[u] = m_busy[u] && !m_rd[u] && m_rj[u] && m_rk[u];
    gsel = -1;
    for (int s = 0; s < NF; s++) begin
      war = 0;
      for (int i = 0; i < NF; i++)
        if (i != s && m_busy[i] && ((m_fj[i] == m_fi[s] && m_rj[i]) ||
                                    (m_fk[i] == m_fi[s] && m_rk[i]))) war = 1;
      if (fu_done[s] && m_busy[s] && m_rd[s] && !war) gsel = s;
    end
    wid   = gsel + 1;
    e.gnt = '0;
    if (gsel >= 0) e.gnt[gsel] = 1'b1;
    e.wbv = (gsel >= 0);
    e.wbr = (gsel >= 0) ? m_fi[gsel] : 0;
    e.rdy = !m_busy[unit] && m_rs[dst] == 0;
    fire  = v && e.rdy;
    p1 = (m_rs[s1] == wid) ? 0 : m_rs[s1];
    p2 = (m_rs[s2] == wid) ? 0 : m_rs[s2];
    exp_q.push_back(e);
    if (gsel >= 0) begin
      if (m_rs[m_fi[gsel]] == wid) m_rs[m_fi[gsel]] = 0;
      for (int i = 0; i < NF; i++) if (i != gsel) begin
        if (m_qj[i] == wid) begin m_qj[i] = 0; m_rj[i] = 1; end
        if (m_qk[i] == wid) begin m_qk[i] = 0; m_rk[i] = 1; end
      end
      m_busy[gsel] = 0; m_rd[gsel] = 0; m_rj[gsel] = 0; m_rk[gsel] = 0;
      m_qj[gsel] = 0; m_qk[gsel] = 0;
    end
    for (int u = 0; u < NF; u++) begin
      if (e.go[u]) begin
        m_rd[u] = 1; m_rj[u] = 0; m_rk[u] = 0; cnt[u] = lat_of(u);
      end else if (cnt[u] > 0) cnt[u]--;
    end
    if (fire) begin
      m_busy[unit] = 1; m_rd[unit] = 0;
      m_fi[unit] = dst; m_fj[unit] = s1; m_fk[unit] = s2;
      m_qj[unit] = p1; m_qk[unit] = p2;
      m_rj[unit] = (p1 == 0); m_rk[unit] = (p2 == 0);
      m_rs[dst] = unit + 1;
    end
    acc = fire;
  endtask

  task automatic push_instr(input int unit, input int dst, input int s1,
                            input int s2, output int tries);
    bit acc = 0;
    tries = 0;
    while (!acc) begin
      step(1, unit, dst, s1, s2, acc);
      tries++;
    end
  endtask

  task automatic drain();
    bit acc, any;
    for (int k = 0; k < 300; k++) begin
      any = 0;
      for (int u = 0; u < NF; u++) any |= m_busy[u];
      if (!any) break;
      step(0, 0, 0, 0, 0, acc);
    end
  endtask

  initial begin
    int t;
    bit acc, hold;
    int v, un, d, a, b;
    for (int u = 0; u < NF; u++) begin
      m_busy[u] = 0; m_rd[u] = 0; m_rj[u] = 0; m_rk[u] = 0;
      m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0; m_qj[u] = 0; m_qk[u] = 0;
      cnt[u] = 0; go_at[u] = 0; gnt_at[u] = 0;
    end
    for (int r = 0; r < NR; r++) m_rs[r] = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    #1;
    chk("R1 iss_ready after reset", int'(iss_ready), 1);
    chk("R1 fu_go after reset", int'(fu_go), 0);
    chk("R1 fu_wgrant after reset", int'(fu_wgrant), 0);
    chk("R1 wb_valid after reset", int'(wb_valid), 0);

    // R4: RAW consumer accepted at once, reads only after producer writes
    push_instr(2, 5, 1, 2, t);
    push_instr(0, 6, 5, 3, t);
    chk("R4 RAW does not block issue (tries)", t, 1);
    drain();
    chk("R4 consumer read after producer write", int'(go_at[0] > gnt_at[2]), 1);

    // R3: second writer of the same register is held off
    push_instr(3, 4, 0, 1, t);
    push_instr(1, 4, 2, 3, t);
    chk("R3 WAW stall observed", int'(t > 1), 1);
    drain();

    // R6: fast writer of r7 waits for a reader stalled on another source
    push_instr(3, 1, 2, 3, t);
    push_instr(2, 6, 1, 7, t);
    push_instr(0, 7, 0, 0, t);
    drain();
    chk("R6 writer granted after pending reader", int'(gnt_at[0] > go_at[2]), 1);

    // hazard-dense random stream with held payloads under back-pressure
    hold = 0;
    v = 0; un = 0; d = 0; a = 0; b = 0;
    for (int k = 0; k < 4000; k++) begin
      if (!hold) begin
        v  = (rnd() % 10) < 7;
        un = rnd() % NF;
        d  = rnd() % NR;
        a  = rnd() % NR;
        b  = rnd() % NR;
      end
      step(v[0], un, d, a, b, acc);
      hold = v[0] && !acc;
    end
    drain();
    @(negedge clk);
    #3;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule